// File: doc/BRIEF.md
# Loopback and Power-Down Mode Controller

This block sets the datapath routing and the power state of a single-channel line transceiver. A strap input picks the control source. In hardware mode, device pins drive the block. In software mode, register bits drive it. The block produces:

- local-loopback and remote-loopback selects,
- transmit and receive power-down enables,
- a transmit output enable that tristates the coded line drivers.

Local loopback sends transmit clock and data into the receive path. Remote loopback sends recovered receive clock and data back out through the transmitter.

The block also raises an active-low, level-sensitive transmit interrupt from two status flags, transmit loss-of-lock and FIFO error.

- In hardware mode, the interrupt is the plain OR of the two flags.
- In software mode, each flag sets a sticky status bit that is cleared by writing one to it. Each bit has its own mask.

Every level input passes through a two-flop synchroniser. Every output comes from a register.

The loopback selection is a three-state machine with these states:

- **ST_NORMAL**: no loopback.
- **ST_REMOTE**: remote loopback.
- **ST_LOCAL**: local loopback.

Its transitions are:

- **ST_NORMAL**: moves to whichever state is requested.
- **ST_REMOTE**: returns to ST_NORMAL on any request other than remote.
- **ST_LOCAL**: returns to ST_NORMAL on any request other than local.

So a change between the two loopbacks always spends one cycle in ST_NORMAL.

Top module: `lbpd_ctrl`

## Requirements
- R1: After reset, lpbk_local=0, lpbk_remote=0, tx_pd=0, rx_pd=0, tx_oe=1, irq_n=1 and irq_status=0.
- R2: In software mode (hw_mode=0):
  - reg_llbk=1 selects local loopback.
  - reg_rlbk=1 with reg_llbk=0 selects remote loopback.
  - When both are 1, local loopback wins.
- R3: In hardware mode (hw_mode=1), the loopback pin decodes as follows:
  - lpbk_pin_lo=1 means pin low, which is normal operation (this includes the case where both qualifiers are 1).
  - lpbk_pin_lo=0 with lpbk_pin_hi=1 means pin high, which is local loopback.
  - Both qualifiers at 0 means pin floating, which is remote loopback.
  - reg_llbk and reg_rlbk are ignored.
- R4: Switching directly between remote and local loopback passes through exactly one cycle with both selects at 0.
- R5: In software mode, reg_txpd drives tx_pd and reg_rxpd drives rx_pd, independently of each other. In hardware mode, rx_pd stays 0 and both register bits are ignored.
- R6: txpd_pin=1 forces tx_pd=1 in both modes.
- R7: tx_oe is 0 exactly while tx_pd is 1.
- R8: In hardware mode, irq_n is 0 while tx_lol or tx_ferr is 1, regardless of reg_mask.
- R9: irq_status bit 0 is loss-of-lock and bit 1 is FIFO error.
  - A bit sets while its source is 1 and stays set after the source drops.
  - A cycle with clr_wr=1 clears every bit whose clr_data bit is 1.
  - If the source is still 1, setting wins over clearing.
- R10: In software mode, irq_n is 0 while any irq_status bit is 1 and its reg_mask bit (same bit position) is 0.
- R11: Loopback selects, tx_pd, rx_pd, tx_oe, hardware-mode irq_n and irq_status change on the third rising clock edge after an input change. Software-mode irq_n changes on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_mode | input | 1 | 1 = pin control, 0 = register control |
| lpbk_pin_hi | input | 1 | Loopback pin qualifier: pin driven high |
| lpbk_pin_lo | input | 1 | Loopback pin qualifier: pin driven low |
| txpd_pin | input | 1 | Transmit power-down pin, active in both modes |
| reg_llbk | input | 1 | Register bit: local loopback |
| reg_rlbk | input | 1 | Register bit: remote loopback |
| reg_txpd | input | 1 | Register bit: transmit power-down |
| reg_rxpd | input | 1 | Register bit: receive power-down |
| reg_mask | input | 2 | Interrupt mask per source, 1 = masked |
| tx_lol | input | 1 | Transmit loss-of-lock status |
| tx_ferr | input | 1 | Transmit FIFO error status |
| clr_wr | input | 1 | Status clear write strobe (clock domain) |
| clr_data | input | 2 | Write-one-to-clear data for irq_status |
| lpbk_local | output | 1 | Local loopback select |
| lpbk_remote | output | 1 | Remote loopback select |
| tx_pd | output | 1 | Transmit power-down |
| rx_pd | output | 1 | Receive power-down |
| tx_oe | output | 1 | Transmit line output enable, 0 = tristate |
| irq_n | output | 1 | Transmit interrupt, active low, level |
| irq_status | output | 2 | Sticky interrupt status |

## Verification
Each input change is driven on a falling edge. The two synchroniser flops take the first two rising edges, and the state or output register takes the third. The sticky-status path adds one more edge before the software-mode interrupt. Steady-state checks therefore wait five clock cycles before sampling on a falling edge. Dedicated latency checks sample one edge early and exactly on the due edge. The remote-to-local transition is sampled on its third and fourth edges to see the single cycle spent in ST_NORMAL.

// File: rtl/lbpd_pkg.sv
package lbpd_pkg;
    localparam int NSRC     = 2;
    localparam int IDX_LOL  = 0;
    localparam int IDX_FERR = 1;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'd0,
        LM_REMOTE = 2'd1,
        LM_LOCAL  = 2'd2
    } lmode_t;
endpackage

// File: rtl/lbpd_sync.sv
module lbpd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lbpd_loop_fsm.sv
module lbpd_loop_fsm
    import lbpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  lmode_t req,
    output logic   sel_local,
    output logic   sel_remote
);
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_REMOTE = 2'd1,
        ST_LOCAL  = 2'd2
    } state_t;

    state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (req == LM_LOCAL)       state_d = ST_LOCAL;
                else if (req == LM_REMOTE) state_d = ST_REMOTE;
            end
            ST_REMOTE: if (req != LM_REMOTE) state_d = ST_NORMAL;
            ST_LOCAL:  if (req != LM_LOCAL)  state_d = ST_NORMAL;
            default:   state_d = ST_NORMAL;
        endcase
    end

    always_comb begin
        sel_local  = 1'b0;
        sel_remote = 1'b0;
        unique case (state_q)
            ST_NORMAL: ;
            ST_REMOTE: sel_remote = 1'b1;
            ST_LOCAL:  sel_local  = 1'b1;
            default:   ;
        endcase
    end

    // R4: no direct swap between the two loopback paths
    a_r4_no_direct_swap_rl: assert property (@(posedge clk) disable iff (!rst_n)
        sel_remote |=> !sel_local);
    a_r4_no_direct_swap_lr: assert property (@(posedge clk) disable iff (!rst_n)
        sel_local |=> !sel_remote);
endmodule

// File: rtl/lbpd_irq.sv
module lbpd_irq
    import lbpd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] mask,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_data,
    output logic [NSRC-1:0] status,
    output logic            irq_n
);
    logic [NSRC-1:0] sticky_q, clr_vec;

    assign clr_vec = clr_wr ? clr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
            irq_n    <= 1'b1;
        end else begin
            sticky_q <= (sticky_q & ~clr_vec) | src;
            irq_n    <= hw ? ~(|src) : ~(|(sticky_q & ~mask));
        end
    end

    assign status = sticky_q;

    // R9: a set status bit holds until it is written with one
    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status[IDX_LOL] && !(clr_wr && clr_data[IDX_LOL])) |=> status[IDX_LOL]);
    // R9: an active source always leaves its bit set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        src[IDX_FERR] |=> status[IDX_FERR]);
    // R10: fully masked software mode keeps the interrupt quiet
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw && (&mask)) |=> irq_n);
    // R8: hardware mode follows the sources directly
    a_r8_hw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (hw && (|src)) |=> !irq_n);
endmodule

// File: rtl/lbpd_ctrl.sv
module lbpd_ctrl
    import lbpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_mode,
    input  logic            lpbk_pin_hi,
    input  logic            lpbk_pin_lo,
    input  logic            txpd_pin,
    input  logic            reg_llbk,
    input  logic            reg_rlbk,
    input  logic            reg_txpd,
    input  logic            reg_rxpd,
    input  logic [NSRC-1:0] reg_mask,
    input  logic            tx_lol,
    input  logic            tx_ferr,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_data,
    output logic            lpbk_local,
    output logic            lpbk_remote,
    output logic            tx_pd,
    output logic            rx_pd,
    output logic            tx_oe,
    output logic            irq_n,
    output logic [NSRC-1:0] irq_status
);
    localparam int SW = 8 + 2*NSRC;

    logic [SW-1:0]   raw_in, syn;
    logic            s_hw, s_hi, s_lo, s_txpd_pin, s_llbk, s_rlbk, s_txpd, s_rxpd;
    logic [NSRC-1:0] s_mask, s_src;
    lmode_t          req;

    assign raw_in = {hw_mode, lpbk_pin_hi, lpbk_pin_lo, txpd_pin,
                     reg_llbk, reg_rlbk, reg_txpd, reg_rxpd,
                     reg_mask, tx_ferr, tx_lol};

    lbpd_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    assign {s_hw, s_hi, s_lo, s_txpd_pin, s_llbk, s_rlbk, s_txpd, s_rxpd,
            s_mask, s_src} = syn;

    always_comb begin
        if (s_hw) begin
            if (s_lo)      req = LM_NORMAL;
            else if (s_hi) req = LM_LOCAL;
            else           req = LM_REMOTE;
        end else begin
            if (s_llbk)      req = LM_LOCAL;
            else if (s_rlbk) req = LM_REMOTE;
            else             req = LM_NORMAL;
        end
    end

    lbpd_loop_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req),
        .sel_local(lpbk_local), .sel_remote(lpbk_remote)
    );

    logic txpd_d;
    assign txpd_d = s_txpd_pin | (!s_hw & s_txpd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_pd <= 1'b0;
            tx_oe <= 1'b1;
            rx_pd <= 1'b0;
        end else begin
            tx_pd <= txpd_d;
            tx_oe <= !txpd_d;
            rx_pd <= !s_hw & s_rxpd;
        end
    end

    lbpd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .hw(s_hw), .src(s_src), .mask(s_mask),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .status(irq_status), .irq_n(irq_n)
    );

    // R6: the pin forces transmit power-down in every mode
    a_r6_pin_forces_txpd: assert property (@(posedge clk) disable iff (!rst_n)
        s_txpd_pin |=> tx_pd);
    // R7: line drivers are off whenever the transmitter is powered down
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pd |-> !tx_oe);
    // R5: hardware mode never powers down the receiver
    a_r5_hw_no_rxpd: assert property (@(posedge clk) disable iff (!rst_n)
        s_hw |=> !rx_pd);
endmodule

// File: tb/sim_lbpd_ctrl.sv
`timescale 1ns/1ps
module sim_lbpd_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_mode = 0, lpbk_pin_hi = 0, lpbk_pin_lo = 1, txpd_pin = 0;
    logic reg_llbk = 0, reg_rlbk = 0, reg_txpd = 0, reg_rxpd = 0;
    logic [1:0] reg_mask = 2'b00, clr_data = 2'b00;
    logic tx_lol = 0, tx_ferr = 0, clr_wr = 0;
    logic lpbk_local, lpbk_remote, tx_pd, rx_pd, tx_oe, irq_n;
    logic [1:0] irq_status;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lbpd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .lpbk_pin_hi(lpbk_pin_hi),
        .lpbk_pin_lo(lpbk_pin_lo), .txpd_pin(txpd_pin), .reg_llbk(reg_llbk),
        .reg_rlbk(reg_rlbk), .reg_txpd(reg_txpd), .reg_rxpd(reg_rxpd),
        .reg_mask(reg_mask), .tx_lol(tx_lol), .tx_ferr(tx_ferr), .clr_wr(clr_wr),
        .clr_data(clr_data), .lpbk_local(lpbk_local), .lpbk_remote(lpbk_remote),
        .tx_pd(tx_pd), .rx_pd(rx_pd), .tx_oe(tx_oe), .irq_n(irq_n),
        .irq_status(irq_status)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 loop", {lpbk_local, lpbk_remote}, 8'h0);
        chk("R1 power", {tx_pd, rx_pd, tx_oe}, 8'h1);
        chk("R1 irq", {irq_n, irq_status}, 8'h4);
    endtask

    task automatic t_sw_loop();
        hw_mode = 0; reg_llbk = 1; reg_rlbk = 0;
        repeat (2) @(negedge clk);
        chk("R11 local not yet", lpbk_local, 0);
        @(negedge clk);
        chk("R11 local on 3rd edge", lpbk_local, 1);
        chk("R2 local", {lpbk_local, lpbk_remote}, 8'h2);
        reg_rlbk = 1; settle();
        chk("R2 both -> local", {lpbk_local, lpbk_remote}, 8'h2);
        reg_llbk = 0; settle();
        chk("R2 remote", {lpbk_local, lpbk_remote}, 8'h1);
        // R4: direct remote-to-local request
        reg_llbk = 1; reg_rlbk = 0;
        repeat (2) @(negedge clk);
        chk("R4 remote held", {lpbk_local, lpbk_remote}, 8'h1);
        @(negedge clk);
        chk("R4 gap cycle", {lpbk_local, lpbk_remote}, 8'h0);
        @(negedge clk);
        chk("R4 local after gap", {lpbk_local, lpbk_remote}, 8'h2);
        reg_llbk = 0; settle();
        chk("R2 normal", {lpbk_local, lpbk_remote}, 8'h0);
    endtask

    task automatic t_hw_loop();
        hw_mode = 1; reg_llbk = 1; lpbk_pin_lo = 1; lpbk_pin_hi = 0; settle();
        chk("R3 low normal, reg ignored", {lpbk_local, lpbk_remote}, 8'h0);
        lpbk_pin_lo = 0; lpbk_pin_hi = 1; settle();
        chk("R3 high local", {lpbk_local, lpbk_remote}, 8'h2);
        lpbk_pin_hi = 0; settle();
        chk("R3 float remote", {lpbk_local, lpbk_remote}, 8'h1);
        lpbk_pin_lo = 1; lpbk_pin_hi = 1; settle();
        chk("R3 both qualifiers normal", {lpbk_local, lpbk_remote}, 8'h0);
        reg_llbk = 0; lpbk_pin_hi = 0;
    endtask

    task automatic t_power();
        hw_mode = 0; reg_txpd = 1; reg_rxpd = 0; settle();
        chk("R5 tx only", {tx_pd, rx_pd}, 8'h2);
        chk("R7 oe off", tx_oe, 0);
        reg_txpd = 0; reg_rxpd = 1;
        repeat (2) @(negedge clk);
        chk("R11 rx_pd not yet", rx_pd, 0);
        @(negedge clk);
        chk("R11 rx_pd on 3rd edge", rx_pd, 1);
        settle();
        chk("R5 rx only", {tx_pd, rx_pd, tx_oe}, 8'h3);
        hw_mode = 1; reg_txpd = 1; settle();
        chk("R5 hw ignores reg bits", {tx_pd, rx_pd, tx_oe}, 8'h1);
        txpd_pin = 1; settle();
        chk("R6 pin in hw mode", {tx_pd, tx_oe}, 8'h2);
        hw_mode = 0; reg_txpd = 0; reg_rxpd = 0; settle();
        chk("R6 pin in sw mode", {tx_pd, tx_oe}, 8'h2);
        txpd_pin = 0; settle();
        chk("R7 oe back on", {tx_pd, tx_oe}, 8'h1);
    endtask

    task automatic t_hw_irq();
        hw_mode = 1; reg_mask = 2'b11; settle();
        tx_ferr = 1;
        repeat (2) @(negedge clk);
        chk("R11 hw irq not yet", irq_n, 1);
        @(negedge clk);
        chk("R8 ferr irq despite mask", irq_n, 0);
        tx_ferr = 0; settle();
        chk("R8 irq follows level", irq_n, 1);
        tx_lol = 1; settle();
        chk("R8 lol irq", irq_n, 0);
        tx_lol = 0; settle();
        clr_data = 2'b11; clr_wr = 1; @(negedge clk); clr_wr = 0;
        settle();
        chk("R9 cleared", irq_status, 0);
    endtask

    task automatic t_sw_irq();
        hw_mode = 0; reg_mask = 2'b00; settle();
        tx_lol = 1; @(negedge clk); tx_lol = 0;
        repeat (2) @(negedge clk);
        chk("R9 status on 3rd edge", irq_status, 2'b01);
        chk("R11 sw irq not yet", irq_n, 1);
        @(negedge clk);
        chk("R10 sw irq on 4th edge", irq_n, 0);
        settle();
        chk("R9 sticky after source drop", irq_status, 2'b01);
        reg_mask = 2'b01; settle();
        chk("R10 masked lol", irq_n, 1);
        chk("R9 status kept under mask", irq_status, 2'b01);
        tx_ferr = 1; settle();
        chk("R10 unmasked ferr", irq_n, 0);
        clr_data = 2'b11; clr_wr = 1; @(negedge clk); clr_wr = 0;
        chk("R9 set wins over clear", irq_status, 2'b10);
        tx_ferr = 0; settle();
        clr_data = 2'b10; clr_wr = 1; @(negedge clk); clr_wr = 0;
        chk("R9 w1c ferr", irq_status, 2'b00);
        settle();
        chk("R10 irq released", irq_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sw_loop();
        t_hw_loop();
        t_power();
        t_hw_irq();
        t_sw_irq();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule